// File: doc/BRIEF.md
# Strided Two-Dimensional Memory-to-Stream Engine

This block reads one rectangular frame out of byte-addressed memory and sends it out as a stream of pixel bytes. Software programs it through a small register window. It sets the run bit, then the frame start address, the number of bytes to take from each line and the byte distance from one line start to the next. The line count is written last. That final write starts the frame. Line n begins at the start address plus n times the stride, and bytes within a line come from consecutive addresses.

On the memory side the engine issues single-byte read requests, one at a time, on a request/grant port. The data comes back later on a valid strobe. Each returned byte goes out on a ready/valid stream. The user flag marks the first byte of the frame, and the last flag marks the final byte of every line. A self-clearing soft-reset bit empties the channel. While a reset is pending, the bit reads back as 1, so software can poll it.

Top module: `s2d_engine`

## Requirements
- R1: After reset, control (0x00), start address (0x5C), bytes per line (0x58), stride (0x54) and line count (0x50) all read 0. Status (0x04) reads 0x3, with bit 0 = halted, bit 1 = idle and bit 2 = error. No read request and no stream beat are active.
- R2: The start address, bytes per line, stride and line count registers read back the values written. The control register keeps the written value when bit 2 is 0. Status bit 0 (halted) equals the inverse of control bit 0 (run).
- R3: A nonzero write to the line count starts a frame when run is 1, the channel is idle and the bytes per line are nonzero. The frame then streams, in order, the bytes at start + n*stride + k, where n is the line number and k the byte within the line.
- R4: The stream user flag is 1 only on the first byte of a frame. The last flag is 1 exactly on byte (bytes per line − 1) of every line.
- R5: While a stream beat is offered and not accepted, its data and both flags stay unchanged and valid stays 1. No read request is raised while a beat is pending.
- R6: A line-count write while run is 0 issues no read request and leaves the channel idle.
- R7: A line-count write while a frame is in progress does not change that frame and does not start another frame after it.
- R8: A line-count write with run set and either the bytes per line or the written value equal to 0 starts nothing and sets status bit 2. The next frame that starts clears bit 2.
- R9: Writing 1 to control bit 2 starts a soft reset. Bit 2 reads 1 until the reset finishes and then reads 0. Afterwards all configuration registers and the run bit are 0 and the status reads 0x3.
- R10: A soft reset issued while a read is outstanding waits for that read to return. It discards the returned byte, so no stream beat appears.
- R11: A read request, once raised, stays raised with an unchanged address until it is granted.
- R12: Status bit 1 (idle) is 0 from the cycle after a frame starts until its last byte has been accepted, and is 1 afterwards.
- R13: Clearing run in the middle of a frame stops new read requests after the one in flight. Setting run again resumes the frame at the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for write and read |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data for cfg_addr (combinational) |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 8 | Returned byte |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 8 | Stream pixel byte |
| m_tuser | output | 1 | First byte of frame |
| m_tlast | output | 1 | Last byte of line |

## Verification
The hardest case to reach from the ports is a soft reset that lands while a read is granted but not yet answered. A fast memory closes that window in a single cycle. To hold it open, the bench memory model returns data after a configurable delay, set to 15 cycles for this case. The stimulus polls the model's grant counter, writes the reset bit immediately after a grant, and then polls control bit 2. It confirms that the bit clears only after the late data has arrived, and that no beat reaches the stream. A paused frame and a line-count write in mid-frame are reached in a similar way, by counting grants and acting at a chosen byte.

// File: rtl/s2d_pkg.sv
// Shared constants and types for the strided 2D memory-to-stream engine.
// Assumes a byte-wide memory read path and byte register offsets.
package s2d_pkg;
    localparam int BYTE_W        = 8;
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_STAT   = 8'h04;
    localparam logic [7:0] OFF_LINES  = 8'h50;
    localparam logic [7:0] OFF_STRIDE = 8'h54;
    localparam logic [7:0] OFF_BPL    = 8'h58;
    localparam logic [7:0] OFF_BASE   = 8'h5C;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SRST_BIT = 2;
    localparam int STAT_HALT_BIT = 0;
    localparam int STAT_IDLE_BIT = 1;
    localparam int STAT_ERR_BIT  = 2;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_REQ,
        MV_WAIT,
        MV_OUT
    } mv_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              user;
        logic              last;
    } beat_t;
endpackage

// File: rtl/s2d_regs.sv
// Register window of the engine: control, status and frame geometry.
// Issues a one-cycle start pulse when the line count is written under the
// right conditions and drives the self-clearing soft reset, which completes
// only once the mover holds no request, read or beat.
// Assumes CFG_W >= ADDR_W and CFG_W >= SIZE_W.
module s2d_regs
    import s2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              eng_busy,
    input  logic              mover_busy,
    output logic              run,
    output logic              srst_busy,
    output logic              start,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] bpl,
    output logic [SIZE_W-1:0] stride,
    output logic [SIZE_W-1:0] lines
);
    logic [CFG_W-1:0]  ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] bpl_q, stride_q, lines_q;
    logic              srst_q, start_q, err_q;
    logic              busy_any, srst_done, wr_ok, geom_ok;

    assign busy_any  = eng_busy | start_q;
    assign srst_done = srst_q & ~mover_busy;
    assign wr_ok     = cfg_we & ~srst_q;
    assign geom_ok   = (cfg_wdata[SIZE_W-1:0] != '0) && (bpl_q != '0);

    // Register writes, start pulse, error flag and soft-reset sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_done) begin
            ctrl_q   <= '0;
            base_q   <= '0;
            bpl_q    <= '0;
            stride_q <= '0;
            lines_q  <= '0;
            srst_q   <= 1'b0;
            start_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_ok) begin
                case (cfg_addr)
                    OFF_CTRL: begin
                        if (cfg_wdata[CTRL_SRST_BIT]) srst_q <= 1'b1;
                        else                          ctrl_q <= cfg_wdata;
                    end
                    OFF_BASE:   base_q   <= cfg_wdata[ADDR_W-1:0];
                    OFF_BPL:    bpl_q    <= cfg_wdata[SIZE_W-1:0];
                    OFF_STRIDE: stride_q <= cfg_wdata[SIZE_W-1:0];
                    OFF_LINES: begin
                        lines_q <= cfg_wdata[SIZE_W-1:0];
                        if (ctrl_q[CTRL_RUN_BIT] && !busy_any) begin
                            if (geom_ok) begin
                                start_q <= 1'b1;
                                err_q   <= 1'b0;
                            end else begin
                                err_q   <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read mux over the register window.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFF_CTRL: begin
                cfg_rdata = ctrl_q;
                cfg_rdata[CTRL_SRST_BIT] = srst_q;
            end
            OFF_STAT: begin
                cfg_rdata[STAT_HALT_BIT] = ~ctrl_q[CTRL_RUN_BIT];
                cfg_rdata[STAT_IDLE_BIT] = ~busy_any;
                cfg_rdata[STAT_ERR_BIT]  = err_q;
            end
            OFF_BASE:   cfg_rdata = CFG_W'(base_q);
            OFF_BPL:    cfg_rdata = CFG_W'(bpl_q);
            OFF_STRIDE: cfg_rdata = CFG_W'(stride_q);
            OFF_LINES:  cfg_rdata = CFG_W'(lines_q);
            default:    cfg_rdata = '0;
        endcase
    end

    assign run       = ctrl_q[CTRL_RUN_BIT] & ~srst_q;
    assign srst_busy = srst_q;
    assign start     = start_q;
    assign base      = base_q;
    assign bpl       = bpl_q;
    assign stride    = stride_q;
    assign lines     = lines_q;
endmodule

// File: rtl/s2d_walker.sv
// Two-dimensional address walker. Takes a snapshot of the geometry on start,
// then steps one byte per advance: along the line, then to the next line
// start by adding the stride to a running line base.
// Assumes start arrives only while inactive and bytes per line / lines != 0.
module s2d_walker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] bpl,
    input  logic [SIZE_W-1:0] stride,
    input  logic [SIZE_W-1:0] lines,
    input  logic              adv,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              first,
    output logic              eol
);
    logic [ADDR_W-1:0] line_base;
    logic [SIZE_W-1:0] col, row, bpl_q, stride_q, lines_q;
    logic              act_q, last_row;

    assign eol      = (col == bpl_q - SIZE_W'(1));
    assign last_row = (row == lines_q - SIZE_W'(1));
    assign first    = (row == '0) && (col == '0);
    assign addr     = line_base + ADDR_W'(col);
    assign active   = act_q;

    // Snapshot on start, then walk bytes and lines.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            act_q     <= 1'b0;
            line_base <= '0;
            col       <= '0;
            row       <= '0;
            bpl_q     <= '0;
            stride_q  <= '0;
            lines_q   <= '0;
        end else if (start) begin
            act_q     <= 1'b1;
            line_base <= base;
            col       <= '0;
            row       <= '0;
            bpl_q     <= bpl;
            stride_q  <= stride;
            lines_q   <= lines;
        end else if (adv && act_q) begin
            if (eol) begin
                col <= '0;
                if (last_row) begin
                    act_q <= 1'b0;
                end else begin
                    row       <= row + SIZE_W'(1);
                    line_base <= line_base + ADDR_W'(stride_q);
                end
            end else begin
                col <= col + SIZE_W'(1);
            end
        end
    end
endmodule

// File: rtl/s2d_mover.sv
// Moves one byte at a time: raises a read request, waits for its data, then
// offers it on the stream until accepted. Only one read is ever in flight.
// A flush (soft reset) stops new requests, drops returned data and any beat.
module s2d_mover
    import s2d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              flush,
    input  logic              w_active,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic              w_first,
    input  logic              w_eol,
    output logic              adv,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [BYTE_W-1:0] m_tdata,
    output logic              m_tuser,
    output logic              m_tlast
);
    mv_state_t         st;
    logic [ADDR_W-1:0] addr_q;
    beat_t             beat_q;

    // Request / wait / offer sequence for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= MV_IDLE;
            addr_q <= '0;
            beat_q <= '0;
        end else begin
            case (st)
                MV_IDLE: if (w_active && run && !flush) begin
                    st          <= MV_REQ;
                    addr_q      <= w_addr;
                    beat_q.user <= w_first;
                    beat_q.last <= w_eol;
                end
                MV_REQ: if (mem_gnt) st <= MV_WAIT;
                MV_WAIT: if (mem_rvalid) begin
                    if (flush) begin
                        st <= MV_IDLE;
                    end else begin
                        st          <= MV_OUT;
                        beat_q.data <= mem_rdata;
                    end
                end
                MV_OUT: if (flush || m_tready) st <= MV_IDLE;
                default: st <= MV_IDLE;
            endcase
        end
    end

    assign adv      = (st == MV_REQ) && mem_gnt;
    assign busy     = (st != MV_IDLE);
    assign mem_req  = (st == MV_REQ);
    assign mem_addr = addr_q;
    assign m_tvalid = (st == MV_OUT);
    assign m_tdata  = beat_q.data;
    assign m_tuser  = beat_q.user;
    assign m_tlast  = beat_q.last;
endmodule

// File: rtl/s2d_engine.sv
// Top of the strided 2D memory-to-stream engine: register window, address
// walker and byte mover. Synchronous active-low reset.
module s2d_engine
    import s2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [BYTE_W-1:0] m_tdata,
    output logic              m_tuser,
    output logic              m_tlast
);
    logic              run, srst_busy, start, busy, mv_busy;
    logic              w_active, w_first, w_eol, adv;
    logic [ADDR_W-1:0] base, w_addr;
    logic [SIZE_W-1:0] bpl, stride, lines;

    assign busy = w_active | mv_busy;

    s2d_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CFG_W(CFG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .eng_busy(busy),
        .mover_busy(mv_busy), .run(run), .srst_busy(srst_busy), .start(start),
        .base(base), .bpl(bpl), .stride(stride), .lines(lines)
    );

    s2d_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(srst_busy && !mv_busy), .start(start),
        .base(base), .bpl(bpl), .stride(stride), .lines(lines), .adv(adv),
        .active(w_active), .addr(w_addr), .first(w_first), .eol(w_eol)
    );

    s2d_mover #(.ADDR_W(ADDR_W)) u_move (
        .clk(clk), .rst_n(rst_n), .run(run), .flush(srst_busy),
        .w_active(w_active), .w_addr(w_addr), .w_first(w_first), .w_eol(w_eol),
        .adv(adv), .busy(mv_busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );
endmodule

// File: rtl/s2d_engine_chk.sv
// Protocol and sequencing properties of the engine, bound to its top.
module s2d_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [7:0]        m_tdata,
    input logic              m_tuser,
    input logic              m_tlast,
    input logic              run,
    input logic              busy,
    input logic              srst_busy
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tuser) && $stable(m_tlast)));

    p_no_req_with_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !mem_req);

    p_start_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(run));

    p_halt_no_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !mem_req) |=> !mem_req);

    p_srst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_busy && !mem_req) |=> !mem_req);

    p_srst_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> (!busy && !m_tvalid && !mem_req));
endmodule

bind s2d_engine s2d_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .run(run), .busy(busy), .srst_busy(srst_busy)
);

// File: tb/tb_s2d_engine.sv
module tb_s2d_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [7:0]  m_tdata;
    logic        m_tuser, m_tlast;

    int checks = 0, fails = 0;
    string cur_req = "R3";
    logic [9:0] expq[$];

    // memory model state
    logic gnt_en = 1'b1, gnt_rand = 1'b0, bp_rand = 1'b0;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int pend_cnt = 0, mem_lat = 0, gnt_cnt = 0, rv_cnt = 0;

    // monitor history
    logic h_v = 0, h_r = 0, h_u = 0, h_l = 0, p_req = 0, p_gnt = 0;
    logic [7:0] h_d = 0;
    logic [31:0] p_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    s2d_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Memory: grant (optionally random), answer after mem_lat cycles.
    assign mem_gnt = gnt_en;
    always @(posedge clk) begin
        gnt_en     <= gnt_rand ? ($urandom % 3 != 0) : 1'b1;
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pat(pend_addr);
                pend       <= 1'b0;
                rv_cnt     <= rv_cnt + 1;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
        if (mem_req && mem_gnt) begin
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            pend_cnt  <= mem_lat;
            gnt_cnt   <= gnt_cnt + 1;
        end
    end

    // Monitor: hold checks, drive ready, pop and compare accepted beats.
    always @(negedge clk) begin
        if (rst_n) begin
            if (h_v && !h_r)
                chk(m_tvalid && m_tdata == h_d && m_tuser == h_u && m_tlast == h_l,
                    "R5", "beat changed while stalled", {22'b0, m_tvalid, m_tuser, m_tlast, 7'b0},
                    {22'b0, 1'b1, h_u, h_l, 7'b0});
            if (p_req && !p_gnt)
                chk(mem_req && mem_addr == p_addr, "R11", "request dropped or moved",
                    mem_addr, p_addr);
            m_tready = bp_rand ? 1'($urandom % 2) : 1'b1;
            if (m_tvalid && m_tready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected beat", {22'b0, m_tdata, m_tuser, m_tlast}, 32'h0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    chk({m_tdata, m_tuser, m_tlast} == e, cur_req, "beat data/user/last",
                        {22'b0, m_tdata, m_tuser, m_tlast}, {22'b0, e});
                end
            end
            h_v = m_tvalid; h_r = m_tready; h_d = m_tdata; h_u = m_tuser; h_l = m_tlast;
            p_req = mem_req; p_gnt = mem_gnt; p_addr = mem_addr;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Driver: push expected beats (R3 addressing, R4 flags) then program.
    task automatic push_frame(input logic [31:0] b, input int h, input int s, input int v);
        for (int r = 0; r < v; r++)
            for (int c = 0; c < h; c++)
                expq.push_back({pat(b + 32'(r * s + c)), (r == 0 && c == 0), (c == h - 1)});
    endtask

    task automatic start_frame(input logic [31:0] b, input int h, input int s, input int v);
        push_frame(b, h, s, v);
        wr(8'h5C, b);
        wr(8'h58, 32'(h));
        wr(8'h54, 32'(s));
        wr(8'h50, 32'(v));
    endtask

    task automatic wait_done(input string rq);
        logic [31:0] d;
        int n = 0;
        while (expq.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, rq, "frame incomplete", 32'(expq.size()), 0);
        rd(8'h04, d);
        chk(d[1] == 1'b1, "R12", "idle after frame", d, d | 32'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [31:0] d;
        int g0, g1, r0, n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk(!mem_req && !m_tvalid, "R1", "outputs idle", {mem_req, m_tvalid}, 0);
        rd(8'h00, d); chk(d == 0, "R1", "ctrl", d, 0);
        rd(8'h04, d); chk(d == 32'h3, "R1", "status", d, 32'h3);
        rd(8'h50, d); chk(d == 0, "R1", "lines", d, 0);
        rd(8'h54, d); chk(d == 0, "R1", "stride", d, 0);
        rd(8'h58, d); chk(d == 0, "R1", "bpl", d, 0);
        rd(8'h5C, d); chk(d == 0, "R1", "base", d, 0);

        // R2 readback
        wr(8'h5C, 32'hDEAD_BEE0); rd(8'h5C, d); chk(d == 32'hDEAD_BEE0, "R2", "base", d, 32'hDEAD_BEE0);
        wr(8'h58, 32'h0123); rd(8'h58, d); chk(d == 32'h0123, "R2", "bpl", d, 32'h0123);
        wr(8'h54, 32'h0456); rd(8'h54, d); chk(d == 32'h0456, "R2", "stride", d, 32'h0456);
        wr(8'h00, 32'h93); rd(8'h00, d); chk(d == 32'h93, "R2", "ctrl", d, 32'h93);
        rd(8'h04, d); chk(d[0] == 1'b0, "R2", "halted clear with run", d, 32'h2);

        // R3/R4/R12 frame with stride larger than line
        cur_req = "R3";
        start_frame(32'h1000, 5, 8, 3);
        rd(8'h04, d); chk(d[1] == 1'b0, "R12", "busy during frame", d, 0);
        wait_done("R3");

        // R5/R11 contiguous frame under backpressure and grant stalls
        cur_req = "R5";
        gnt_rand = 1'b1; bp_rand = 1'b1;
        start_frame(32'h2040, 4, 4, 6);
        wait_done("R5");

        // R4 single-byte frame: first and last together
        cur_req = "R4";
        start_frame(32'h3333, 1, 1, 1);
        wait_done("R4");
        gnt_rand = 1'b0; bp_rand = 1'b0;

        // R6 line count written while halted
        cur_req = "R6";
        wr(8'h00, 32'h0);
        g0 = gnt_cnt;
        wr(8'h58, 32'h4);
        wr(8'h50, 32'h2);
        repeat (20) @(negedge clk);
        chk(gnt_cnt == g0, "R6", "requests while halted", 32'(gnt_cnt), 32'(g0));
        rd(8'h04, d); chk(d == 32'h3, "R6", "status halted idle", d, 32'h3);
        wr(8'h00, 32'h93);

        // R7 line count rewritten mid-frame
        cur_req = "R7";
        gnt_rand = 1'b1;
        g0 = gnt_cnt;
        start_frame(32'h4000, 3, 5, 4);
        n = 0;
        while (gnt_cnt < g0 + 2 && n < 1000) begin @(negedge clk); n++; end
        wr(8'h50, 32'h9);
        wait_done("R7");
        repeat (30) @(negedge clk);
        chk(gnt_cnt == g0 + 12, "R7", "request count", 32'(gnt_cnt), 32'(g0 + 12));
        gnt_rand = 1'b0;

        // R8 zero geometry
        cur_req = "R8";
        g0 = gnt_cnt;
        wr(8'h58, 32'h0); wr(8'h50, 32'h3);
        rd(8'h04, d); chk(d == 32'h6, "R8", "error on zero bpl", d, 32'h6);
        wr(8'h58, 32'h4); wr(8'h50, 32'h0);
        rd(8'h04, d); chk(d == 32'h6, "R8", "error on zero lines", d, 32'h6);
        repeat (10) @(negedge clk);
        chk(gnt_cnt == g0, "R8", "no requests", 32'(gnt_cnt), 32'(g0));
        start_frame(32'h5000, 2, 3, 2);
        wait_done("R8");
        rd(8'h04, d); chk(d == 32'h2, "R8", "error cleared by start", d, 32'h2);

        // R13 pause and resume
        cur_req = "R13";
        mem_lat = 3;
        g0 = gnt_cnt;
        start_frame(32'h0300, 4, 6, 3);
        n = 0;
        while (gnt_cnt < g0 + 3 && n < 1000) begin @(negedge clk); n++; end
        wr(8'h00, 32'h0);
        repeat (15) @(negedge clk);
        g1 = gnt_cnt;
        rd(8'h04, d); chk(d[0] == 1'b1, "R13", "halted while paused", d, 32'h1);
        repeat (30) @(negedge clk);
        chk(gnt_cnt == g1, "R13", "no requests while paused", 32'(gnt_cnt), 32'(g1));
        wr(8'h00, 32'h93);
        wait_done("R13");
        chk(gnt_cnt == g0 + 12, "R13", "total requests", 32'(gnt_cnt), 32'(g0 + 12));

        // R9/R10 soft reset with a read outstanding
        cur_req = "R10";
        mem_lat = 15;
        g0 = gnt_cnt;
        wr(8'h5C, 32'h6000); wr(8'h58, 32'h8); wr(8'h54, 32'h8); wr(8'h50, 32'h2);
        n = 0;
        while (gnt_cnt == g0 && n < 1000) begin @(negedge clk); n++; end
        r0 = rv_cnt;
        wr(8'h00, 32'h4);
        rd(8'h00, d); chk(d[2] == 1'b1, "R9", "reset bit pending", d, 32'h4);
        n = 0;
        while (d[2] && n < 200) begin rd(8'h00, d); n++; end
        chk(d == 0, "R9", "ctrl after reset", d, 0);
        chk(rv_cnt > r0, "R10", "reset waited for outstanding read", 32'(rv_cnt), 32'(r0 + 1));
        rd(8'h04, d); chk(d == 32'h3, "R9", "status after reset", d, 32'h3);
        rd(8'h5C, d); chk(d == 0, "R9", "base cleared", d, 0);
        rd(8'h58, d); chk(d == 0, "R9", "bpl cleared", d, 0);
        rd(8'h54, d); chk(d == 0, "R9", "stride cleared", d, 0);
        rd(8'h50, d); chk(d == 0, "R9", "lines cleared", d, 0);
        g1 = gnt_cnt;
        repeat (40) @(negedge clk);
        chk(gnt_cnt == g1, "R9", "no requests after reset", 32'(gnt_cnt), 32'(g1));
        chk(!m_tvalid, "R10", "no beat after reset", 32'(m_tvalid), 0);

        report();
    end
endmodule